// File: doc/BRIEF.md
# Port Statistics Snapshot and Readout Unit

This block keeps a small, fixed set of saturating traffic counters for each switch port and exposes them through a narrow 16-bit register window. Per-port event strobes drive the live counters. A host reads a port's statistics in two steps. It first issues a snapshot command, which copies every counter of one port into a capture bank. It then issues indexed read commands, and each one loads one captured 32-bit word into a pair of 16-bit data registers.

Every command sets a busy flag in the command register. The host polls that flag until hardware clears it. A snapshot copies one counter per cycle, so it stays busy for `NUM_CNTS` cycles. A read completes in a single cycle. Live counters keep counting throughout a snapshot. Once a counter has been copied, later increments leave the captured value unchanged.

Counters wider than 32 bits take two consecutive read indexes. The lower index returns the low word, so the host reads index n and then n+1. `NUM_CNTS` should stay at 9 or below so that a snapshot finishes inside a 10-poll budget. `NUM_CNTS` times the words per counter must not exceed 64.

Top module: `port_stat_snap`

## Requirements
- R1: After the asynchronous active-low reset, all live and captured counters are zero, the busy flag is clear, and the command, data-high and data-low registers all read 0x0000.
- R2: Register offset 0x1D is the command register. Reading it returns the busy flag in bit 15 and bits 14:0 of the last accepted command. Offset 0x1E reads bits 31:16 of the loaded word, and offset 0x1F reads bits 15:0. Any other offset reads zero, and writes to any offset other than 0x1D have no effect.
- R3: A write to 0x1D is accepted only when busy is clear, bit 15 of the write data is 1, and bits 14:12 are 3'b101 (snapshot, port number in bits 5:0) or 3'b100 (read, index in bits 5:0). An accepted command shows busy set from the next cycle. Any other write leaves busy and the command register unchanged.
- R4: A snapshot stays busy for exactly `NUM_CNTS` cycles. In busy cycle k it copies counter k of the selected port, taking the live value of that cycle. A port number of `NUM_PORTS` or above captures zeros.
- R5: Live counter c of port p increments by one in each cycle in which strobe bit p*NUM_CNTS+c is high. Snapshots do not disturb the live counters, and increments after a counter has been copied do not change its captured value.
- R6: A read command stays busy for exactly one cycle and loads the selected 32-bit word into the data registers. The data registers change at no other time.
- R7: With a counter width above 32, captured counter c is read as index 2c (bits 31:0) and index 2c+1 (bits 63:32, zero-extended). With a width of 32 or less, counter c is index c, zero-extended.
- R8: A read of an index beyond the implemented words loads zero and still completes in one cycle.
- R9: A live counter that reaches all ones holds that value under further strobes.
- R10: A command write made while busy is set is ignored. The running operation and the command register are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| inc_i | input | NUM_PORTS*NUM_CNTS | Event strobes, bit p*NUM_CNTS+c advances counter c of port p |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 5 | Register offset |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data for reg_addr_i, combinational |

## Verification
The bench drives increments on the same port while that port is being snapshotted. A design that copied every counter at once, or that held off the live counters, would then disagree with the per-cycle model on the captured values. It reads both halves of every wide counter and indexes past the last word. A wrong half order or an index that aliases would return the wrong word, or a non-zero value. It sends commands with a clear bit 15, an unknown opcode, commands to other offsets and commands issued while busy. A decoder that was too loose would start an operation or overwrite the command register. A second small instance drives one counter past its maximum, and a counter that wrapped would read back near zero.

// File: rtl/psu_pkg.sv
package psu_pkg;
  localparam logic [4:0] ADDR_CMD = 5'h1D;
  localparam logic [4:0] ADDR_DHI = 5'h1E;
  localparam logic [4:0] ADDR_DLO = 5'h1F;
  localparam logic [2:0] OPC_READ = 3'b100;
  localparam logic [2:0] OPC_SNAP = 3'b101;
  localparam int ARG_W = 6;
  localparam int CMD_W = 15;
  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SNAP = 2'd1,
    ST_READ = 2'd2
  } psu_state_e;
endpackage

// File: rtl/psu_live_bank.sv
module psu_live_bank #(
  parameter int NUM_PORTS = 8,
  parameter int NUM_CNTS  = 6,
  parameter int CNT_W     = 32
) (
  input  logic                                          clk_i,
  input  logic                                          rst_ni,
  input  logic [NUM_PORTS*NUM_CNTS-1:0]                 inc_i,
  output logic [NUM_PORTS-1:0][NUM_CNTS-1:0][CNT_W-1:0] live_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    for (genvar c = 0; c < NUM_CNTS; c++) begin : g_cnt
      logic [CNT_W-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else if (inc_i[p*NUM_CNTS+c] && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      end
      assign live_o[p][c] = cnt_q;
    end
  end
endmodule

// File: rtl/psu_ctrl.sv
module psu_ctrl import psu_pkg::*; #(
  parameter int NUM_CNTS = 6,
  localparam int STEP_W  = (NUM_CNTS > 1) ? $clog2(NUM_CNTS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [4:0]        addr_i,
  input  logic [15:0]       wdata_i,
  output logic              busy_o,
  output logic              snap_o,
  output logic [ARG_W-1:0]  arg_o,
  output logic [STEP_W-1:0] step_o,
  output logic [CMD_W-1:0]  cmd_o
);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_CNTS - 1);

  psu_state_e state_q;
  logic [2:0] opc;
  logic       accept;

  assign opc    = wdata_i[14:12];
  assign accept = we_i && (addr_i == ADDR_CMD) && wdata_i[15] && (state_q == ST_IDLE)
                  && (opc == OPC_READ || opc == OPC_SNAP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      arg_o   <= '0;
      step_o  <= '0;
      cmd_o   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          state_q <= (opc == OPC_SNAP) ? ST_SNAP : ST_READ;
          arg_o   <= wdata_i[ARG_W-1:0];
          step_o  <= '0;
          cmd_o   <= wdata_i[CMD_W-1:0];
        end
        ST_SNAP: begin
          if (step_o == LAST_STEP) state_q <= ST_IDLE;
          else step_o <= step_o + 1'b1;
        end
        ST_READ: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign snap_o = (state_q == ST_SNAP);
endmodule

// File: rtl/psu_capture.sv
module psu_capture import psu_pkg::*; #(
  parameter int NUM_PORTS = 8,
  parameter int NUM_CNTS  = 6,
  parameter int CNT_W     = 32,
  parameter int STEP_W    = 3
) (
  input  logic                                          clk_i,
  input  logic                                          rst_ni,
  input  logic [NUM_PORTS-1:0][NUM_CNTS-1:0][CNT_W-1:0] live_i,
  input  logic                                          copy_i,
  input  logic                                          fetch_i,
  input  logic [ARG_W-1:0]                              arg_i,
  input  logic [STEP_W-1:0]                             step_i,
  output logic [WORD_W-1:0]                             data_o
);
  localparam int WPC   = (CNT_W + WORD_W - 1) / WORD_W;
  localparam int EXT_W = WPC * WORD_W;

  logic [NUM_CNTS-1:0][CNT_W-1:0] cap_q;
  logic [NUM_CNTS-1:0][EXT_W-1:0] cap_ext;
  logic [CNT_W-1:0]               src;
  logic [WORD_W-1:0]              word;

  for (genvar c = 0; c < NUM_CNTS; c++) begin : g_ext
    assign cap_ext[c] = EXT_W'(cap_q[c]);
  end

  // source counter for the current copy step; unknown ports give zero
  always_comb begin
    src = '0;
    for (int p = 0; p < NUM_PORTS; p++)
      for (int c = 0; c < NUM_CNTS; c++)
        if (arg_i == ARG_W'(p) && step_i == STEP_W'(c)) src = live_i[p][c];
  end

  // indexed word, low word of a counter first
  always_comb begin
    word = '0;
    for (int c = 0; c < NUM_CNTS; c++)
      for (int h = 0; h < WPC; h++)
        if (arg_i == ARG_W'(c*WPC + h)) word = cap_ext[c][h*WORD_W +: WORD_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q  <= '0;
      data_o <= '0;
    end else begin
      if (copy_i)
        for (int c = 0; c < NUM_CNTS; c++)
          if (step_i == STEP_W'(c)) cap_q[c] <= src;
      if (fetch_i) data_o <= word;
    end
  end
endmodule

// File: rtl/port_stat_snap.sv
module port_stat_snap import psu_pkg::*; #(
  parameter int NUM_PORTS = 8,
  parameter int NUM_CNTS  = 6,
  parameter int CNT_W     = 32
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_PORTS*NUM_CNTS-1:0] inc_i,
  input  logic                          reg_we_i,
  input  logic [4:0]                    reg_addr_i,
  input  logic [15:0]                   reg_wdata_i,
  output logic [15:0]                   reg_rdata_o
);
  localparam int STEP_W = (NUM_CNTS > 1) ? $clog2(NUM_CNTS) : 1;

  logic [NUM_PORTS-1:0][NUM_CNTS-1:0][CNT_W-1:0] live;
  logic              busy;
  logic              snap;
  logic [ARG_W-1:0]  arg;
  logic [STEP_W-1:0] step;
  logic [CMD_W-1:0]  cmd;
  logic [WORD_W-1:0] data;

  psu_live_bank #(.NUM_PORTS(NUM_PORTS), .NUM_CNTS(NUM_CNTS), .CNT_W(CNT_W)) u_live (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .inc_i (inc_i),
    .live_o(live)
  );

  psu_ctrl #(.NUM_CNTS(NUM_CNTS)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (reg_we_i),
    .addr_i (reg_addr_i),
    .wdata_i(reg_wdata_i),
    .busy_o (busy),
    .snap_o (snap),
    .arg_o  (arg),
    .step_o (step),
    .cmd_o  (cmd)
  );

  psu_capture #(
    .NUM_PORTS(NUM_PORTS), .NUM_CNTS(NUM_CNTS), .CNT_W(CNT_W), .STEP_W(STEP_W)
  ) u_cap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .live_i (live),
    .copy_i (busy && snap),
    .fetch_i(busy && !snap),
    .arg_i  (arg),
    .step_i (step),
    .data_o (data)
  );

  always_comb begin
    unique case (reg_addr_i)
      ADDR_CMD: reg_rdata_o = {busy, cmd};
      ADDR_DHI: reg_rdata_o = data[31:16];
      ADDR_DLO: reg_rdata_o = data[15:0];
      default:  reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/port_stat_snap_chk.sv
module port_stat_snap_chk import psu_pkg::*; #(
  parameter int NUM_PORTS = 8,
  parameter int NUM_CNTS  = 6,
  parameter int CNT_W     = 32
) (
  input logic                                          clk_i,
  input logic                                          rst_ni,
  input logic                                          reg_we_i,
  input logic [4:0]                                    reg_addr_i,
  input logic [15:0]                                   reg_wdata_i,
  input logic                                          busy,
  input logic                                          snap,
  input logic [CMD_W-1:0]                              cmd,
  input logic [WORD_W-1:0]                             data,
  input logic [NUM_PORTS-1:0][NUM_CNTS-1:0][CNT_W-1:0] live
);
  logic [7:0] run_q;
  logic       cmd_wr, cmd_ok;

  assign cmd_wr = reg_we_i && reg_addr_i == ADDR_CMD;
  assign cmd_ok = reg_wdata_i[15] && (reg_wdata_i[14:12] == OPC_READ || reg_wdata_i[14:12] == OPC_SNAP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= '0;
    else if (!busy) run_q <= '0;
    else run_q <= run_q + 1'b1;
  end

  AST_CMD_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy && cmd_wr && cmd_ok |=> busy); // R3
  AST_CMD_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy && cmd_wr && !cmd_ok |=> !busy && $stable(cmd)); // R3
  AST_SNAP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && snap && run_q < 8'(NUM_CNTS - 1) |=> busy); // R4
  AST_SNAP_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && snap && run_q == 8'(NUM_CNTS - 1) |=> !busy); // R4
  AST_READ_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && !snap |=> !busy); // R6
  AST_DATA_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |=> $stable(data)); // R6
  AST_BUSY_IGNORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && cmd_wr |=> $stable(cmd)); // R10

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_p
    for (genvar c = 0; c < NUM_CNTS; c++) begin : g_c
      AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        live[p][c] == {CNT_W{1'b1}} |=> live[p][c] == {CNT_W{1'b1}}); // R9
    end
  end
endmodule

bind port_stat_snap port_stat_snap_chk #(
  .NUM_PORTS(NUM_PORTS), .NUM_CNTS(NUM_CNTS), .CNT_W(CNT_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_we_i   (reg_we_i),
  .reg_addr_i (reg_addr_i),
  .reg_wdata_i(reg_wdata_i),
  .busy       (busy),
  .snap       (snap),
  .cmd        (cmd),
  .data       (data),
  .live       (live)
);

// File: tb/tb_port_stat_snap.sv
module tb_port_stat_snap;
  localparam int P = 3;
  localparam int C = 3;
  localparam int W = 40;
  localparam int WPC = (W + 31) / 32;
  localparam longint MAXV = (longint'(1) << W) - 1;

  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic [P*C-1:0] inc = '0;
  logic we = 0, we_s = 0;
  logic [4:0] addr = 5'h1D, addr_s = 5'h1D;
  logic [15:0] wdata = '0, wdata_s = '0;
  logic [15:0] rdata, rdata_s;
  logic [1:0] inc_s = '0;
  logic inc_run = 0;

  port_stat_snap #(.NUM_PORTS(P), .NUM_CNTS(C), .CNT_W(W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .inc_i(inc), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata));

  port_stat_snap #(.NUM_PORTS(1), .NUM_CNTS(2), .CNT_W(4)) dut_sat (
    .clk_i(clk), .rst_ni(rst_n), .inc_i(inc_s), .reg_we_i(we_s),
    .reg_addr_i(addr_s), .reg_wdata_i(wdata_s), .reg_rdata_o(rdata_s));

  int checks = 0, errors = 0;

  // behavioural reference of the main instance
  longint m_live [P][C];
  longint m_cap [C];
  bit m_busy = 0, m_snap = 0;
  int m_arg = 0, m_step = 0;
  logic [14:0] m_cmd = '0;
  logic [31:0] m_data = '0;

  function automatic logic [31:0] m_word(int idx);
    int c = idx / WPC;
    int h = idx % WPC;
    if (c >= C) return 32'd0;
    return 32'(m_cap[c] >> (32 * h));
  endfunction

  function automatic logic [15:0] m_read(logic [4:0] a);
    case (a)
      5'h1D: return {m_busy, m_cmd};
      5'h1E: return m_data[31:16];
      5'h1F: return m_data[15:0];
      default: return 16'h0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < P; p++) for (int c = 0; c < C; c++) m_live[p][c] = 0;
      for (int c = 0; c < C; c++) m_cap[c] = 0;
      m_busy = 0; m_snap = 0; m_arg = 0; m_step = 0; m_cmd = '0; m_data = '0;
    end else begin
      if (m_busy) begin
        if (m_snap) begin
          m_cap[m_step] = (m_arg < P) ? m_live[m_arg][m_step] : 0;
          m_step++;
          if (m_step == C) m_busy = 0;
        end else begin
          m_data = m_word(m_arg);
          m_busy = 0;
        end
      end else if (we && addr == 5'h1D && wdata[15] &&
                   (wdata[14:12] == 3'b101 || wdata[14:12] == 3'b100)) begin
        m_busy = 1; m_snap = (wdata[14:12] == 3'b101);
        m_arg = int'(wdata[5:0]); m_step = 0; m_cmd = wdata[14:0];
      end
      for (int p = 0; p < P; p++)
        for (int c = 0; c < C; c++)
          if (inc[p*C+c] && m_live[p][c] < MAXV) m_live[p][c]++;
    end
  end

  // per-cycle comparison of the visible register
  always @(posedge clk) begin
    #3;
    if (rst_n) begin
      checks++;
      if (rdata !== m_read(addr)) begin
        errors++;
        $display("FAIL R2 cycle compare addr %h got %h exp %h", addr, rdata, m_read(addr));
      end
    end
  end

  always @(negedge clk) inc = inc_run ? (P*C)'($urandom) : '0;

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic wr(bit s, logic [4:0] a, logic [15:0] v);
    @(negedge clk);
    if (s) begin we_s = 1; addr_s = a; wdata_s = v; end
    else begin we = 1; addr = a; wdata = v; end
    @(negedge clk);
    we = 0; we_s = 0; addr = 5'h1D; addr_s = 5'h1D;
  endtask

  task automatic rd(bit s, logic [4:0] a, output logic [15:0] v);
    @(negedge clk);
    if (s) addr_s = a; else addr = a;
    #1 v = s ? rdata_s : rdata;
  endtask

  // called right after wr returns: counts cycles with busy visible
  task automatic busy_len(bit s, output int n);
    n = 0;
    #1;
    while ((s ? rdata_s[15] : rdata[15]) && n < 20) begin
      n++;
      @(negedge clk);
      #1;
    end
  endtask

  task automatic read_word(bit s, int idx, output logic [31:0] w);
    logic [15:0] hi, lo;
    int n;
    wr(s, 5'h1D, 16'hCC00 | 16'(idx));
    busy_len(s, n);
    check("R6 read busy length", 32'(n), 32'd1);
    rd(s, 5'h1E, hi);
    rd(s, 5'h1F, lo);
    w = {hi, lo};
  endtask

  initial begin
    #2000000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic [31:0] w, w0, w1;
    int n;
    repeat (3) @(negedge clk);
    rd(0, 5'h1D, v); check("R1 cmd after reset", 32'(v), 0);
    rd(0, 5'h1E, v); check("R1 data hi after reset", 32'(v), 0);
    rd(0, 5'h1F, v); check("R1 data lo after reset", 32'(v), 0);
    rst_n = 1;
    read_word(0, 0, w); check("R1 captured zero after reset", w, 0);

    // traffic, then snapshot of port 1
    inc_run = 1; repeat (60) @(negedge clk); inc_run = 0;
    wr(0, 5'h1D, 16'hDC01);
    #1 check("R3 busy and command after accept", 32'(rdata), 32'hDC01);
    busy_len(0, n);
    check("R4 snapshot busy length", 32'(n), C);
    rd(0, 5'h1D, v); check("R3 command kept after done", 32'(v), 32'h5C01);
    for (int i = 0; i < C * WPC; i++) begin
      read_word(0, i, w);
      check(((i % 2) == 1) ? "R7 high word" : "R7 low word", w, m_word(i));
    end
    read_word(0, C * WPC, w); check("R8 index past end", w, 0);
    read_word(0, 63, w); check("R8 top index", w, 0);

    // snapshot while counting, then more counting leaves captures alone
    inc_run = 1;
    wr(0, 5'h1D, 16'hDC02);
    busy_len(0, n);
    check("R4 snapshot busy length under traffic", 32'(n), C);
    inc_run = 0;
    read_word(0, 0, w0); check("R5 captured during traffic", w0, m_word(0));
    read_word(0, 4, w1); check("R5 captured late counter", w1, m_word(4));
    inc_run = 1; repeat (40) @(negedge clk); inc_run = 0;
    read_word(0, 0, w); check("R5 capture unchanged by later traffic", w, w0);
    read_word(0, 4, w); check("R5 capture unchanged by later traffic", w, w1);
    wr(0, 5'h1D, 16'hDC02); busy_len(0, n);
    read_word(0, 0, w); check("R5 live kept counting", w, m_word(0));

    // rejected writes
    wr(0, 5'h1D, 16'h5C00);
    #1 check("R3 bit15 clear ignored", 32'(rdata), 32'(m_cmd));
    wr(0, 5'h1D, 16'hEC00);
    #1 check("R3 unknown opcode ignored", 32'(rdata[15]), 0);
    rd(0, 5'h1F, v); w = 32'(v);
    wr(0, 5'h1E, 16'h1234);
    rd(0, 5'h1F, v); check("R2 write to data offset ignored", 32'(v), w);
    rd(0, 5'h05, v); check("R2 unmapped offset reads zero", 32'(v), 0);

    // command during busy
    wr(0, 5'h1D, 16'hDC00);
    wr(0, 5'h1D, 16'hCC03);
    rd(0, 5'h1D, v); check("R10 command while busy ignored", 32'(v[14:0]), 32'h5C00);
    busy_len(0, n);
    rd(0, 5'h1F, v); check("R10 data untouched", 32'(v), 32'(m_data[15:0]));

    // unknown port
    wr(0, 5'h1D, 16'hDC05); busy_len(0, n);
    check("R4 unknown port busy length", 32'(n), C);
    read_word(0, 0, w); check("R4 unknown port captures zero", w, 0);
    read_word(0, 5, w); check("R4 unknown port captures zero", w, 0);

    // saturation on the narrow instance
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); inc_s = (i < 3) ? 2'b11 : 2'b01;
    end
    @(negedge clk); inc_s = '0;
    wr(1, 5'h1D, 16'hDC00); busy_len(1, n);
    check("R4 narrow snapshot busy length", 32'(n), 2);
    read_word(1, 0, w); check("R9 counter held at maximum", w, 32'hF);
    read_word(1, 1, w); check("R5 neighbour count", w, 32'd3);
    read_word(1, 2, w); check("R8 narrow index past end", w, 0);

    repeat (3) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule